// File: doc/BRIEF.md
# Converter Sample Buffer with Interrupt Request

This block sits between an analog-to-digital converter and a host register interface. Each conversion-done strobe pushes one 16-bit sample into a first-in first-out store. The host drains the store through a 16-bit read port, and each read strobe pops one entry. The store holds `DEPTH` entries and signals half-full at `DEPTH/2`, which is 512 of the default 1024.

A byte-wide register port gives access to three things. The control register picks the two interrupt sources and can hold the store disabled. The status byte carries active-low occupancy flags, a sticky overflow bit and the converter busy line. Writing the clear register drops the interrupt request. The request is a level that stays set until that clear write. The store is emptied by writing the control register with the disable bit set and then with it clear.

Top module: `adc_sample_buffer`

## Requirements
- R1: After reset the store is empty, `irq` is 0, `fifo_rdata` is 0 and the control register is 0, so the store is enabled and both source selects are 0.
- R2: Samples come out in arrival order. A `fifo_rd` strobe on a non-empty store presents the oldest sample on `fifo_rdata` from the following cycle.
- R3: A `fifo_rd` strobe on an empty store leaves `fifo_rdata` and the occupancy unchanged.
- R4: Status bit 4 is 0 when the store is empty, bit 5 is 0 when it holds at least `DEPTH/2` samples, and bit 6 is 0 when it holds `DEPTH` samples. Otherwise each of these bits reads 1.
- R5: A conversion strobe on a full store that is not popped in the same cycle discards the sample and sets status bit 3. Bit 3 stays set until the store is disabled.
- R6: Status bit 7 follows the `adc_busy` input.
- R7: While control bit 2 is 1, the store is emptied, bit 3 is cleared and incoming samples are dropped. The enable, disable, enable write sequence leaves the store empty.
- R8: Control bit 0 selects source A. When it is 0, every conversion strobe raises `irq`. When it is 1, only a push that takes occupancy from `DEPTH/2-1` to `DEPTH/2` raises `irq`.
- R9: Control bit 1 selects source B. When it is 0, `timer_tick` raises `irq`. When it is 1, `ext_trig` raises it, and the unselected input has no effect.
- R10: `irq` stays at 1 until a write to address 2 clears it. An event in the same cycle as the clear write wins, and `irq` stays at 1.
- R11: Reading address 0 returns control bits 1:0 in bits 5:4 with all other bits 0. Reading address 1 returns the status byte. Reading addresses 2 and 3 returns 0. The `status` port always carries the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | Conversion-done strobe |
| conv_data | input | DATA_W | Converted sample |
| adc_busy | input | 1 | Converter busy level |
| timer_tick | input | 1 | Pacer tick pulse |
| ext_trig | input | 1 | External trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 interrupt clear |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| fifo_rd | input | 1 | Pop strobe |
| fifo_rdata | output | DATA_W | Popped sample |
| status | output | 8 | Status byte |
| irq | output | 1 | Latched interrupt request |

## Verification
The bench builds the block with `DEPTH` set to 16 and `DATA_W` left at 16. At that depth the half-full crossing, the full store, the overflow drop and the pop-while-full case are each only a few pushes away. A behavioural queue model is stepped with every input on each clock. Its expected read data, interrupt and register bytes are compared with the design's in every cycle, across directed scenarios and a long stretch of mixed random traffic.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
   localparam int REG_AW = 2;
   localparam int REG_DW = 8;

   typedef enum logic [REG_AW-1:0] {
      ADDR_CTRL  = 2'd0,
      ADDR_STAT  = 2'd1,
      ADDR_ICLR  = 2'd2,
      ADDR_SPARE = 2'd3
   } reg_addr_e;

   // Status byte bit positions
   localparam int ST_OVF     = 3;
   localparam int ST_EMPTY_N = 4;
   localparam int ST_HALF_N  = 5;
   localparam int ST_FULL_N  = 6;
   localparam int ST_BUSY    = 7;

   // Mode readback position of the two source selects
   localparam int RB_SEL_LSB = 4;

   typedef struct packed {
      logic fifo_dis;   // bit 2
      logic srcb_ext;   // bit 1
      logic srca_half;  // bit 0
   } ctrl_t;
endpackage

// File: rtl/adcbuf_fifo.sv
module adcbuf_fifo #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              half,
   output logic              full,
   output logic              ovf,
   output logic              half_evt
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int HALF = DEPTH / 2;

   generate
      if (DEPTH < 4 || (DEPTH % 2) != 0) begin : g_bad_depth
         $error("adcbuf_fifo: DEPTH must be even and at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("adcbuf_fifo: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wptr, rptr, wptr_nxt, rptr_nxt;
   logic [CW-1:0]     count;
   logic              push, pop;

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign half  = (count >= CW'(HALF));

   assign pop      = rd_req & ~empty & ~flush;
   assign push     = wr_req & ~flush & (~full | pop);
   assign half_evt = push & ~pop & (count == CW'(HALF - 1));

   // Pointer advance: free wrap for power-of-two depths, compare otherwise
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wptr_nxt = wptr + AW'(1);
         assign rptr_nxt = rptr + AW'(1);
      end else begin : g_wrap
         assign wptr_nxt = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
         assign rptr_nxt = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr    <= '0;
         rptr    <= '0;
         count   <= '0;
         ovf     <= 1'b0;
         rd_data <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (push) wptr <= wptr_nxt;
         if (pop) begin
            rptr    <= rptr_nxt;
            rd_data <= mem[rptr];
         end
         if (push && !pop)      count <= count + CW'(1);
         else if (pop && !push) count <= count - CW'(1);
         if (wr_req && !push) ovf <= 1'b1;
      end
   end

   p_no_overflow_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_req && !rd_req && !flush) |=> (full && ovf));
   p_ovf_sticky_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !flush) |=> ovf);
   p_empty_read_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && empty) |=> $stable(rd_data));
   p_flush_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && !ovf));
endmodule

// File: rtl/adcbuf_irq.sv
module adcbuf_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_a_half,
   input  logic sel_b_ext,
   input  logic conv_evt,
   input  logic half_evt,
   input  logic tick_evt,
   input  logic ext_evt,
   input  logic clr,
   output logic irq_o
);
   logic src_a, src_b, set;

   assign src_a = sel_a_half ? half_evt : conv_evt;
   assign src_b = sel_b_ext  ? ext_evt  : tick_evt;
   assign set   = src_a | src_b;

   always_ff @(posedge clk) begin
      if (!rst_n)   irq_o <= 1'b0;
      else if (set) irq_o <= 1'b1;
      else if (clr) irq_o <= 1'b0;
   end

   p_latch_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr) |=> irq_o);
   p_clear_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !irq_o);
   p_raise_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a_half ? half_evt : conv_evt) |=> irq_o);
   p_raise_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b_ext ? ext_evt : tick_evt) |=> irq_o);
endmodule

// File: rtl/adcbuf_regs.sv
module adcbuf_regs
   import adcbuf_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [REG_DW-1:0] wdata,
   input  logic [REG_DW-1:0] stat,
   output ctrl_t             ctrl,
   output logic              clr,
   output logic [REG_DW-1:0] rdata
);
   logic unused_wbits;
   assign unused_wbits = ^wdata[REG_DW-1:3];

   assign clr = wr & (addr == ADDR_ICLR);

   always_ff @(posedge clk) begin
      if (!rst_n)                          ctrl <= '0;
      else if (wr && (addr == ADDR_CTRL))  ctrl <= ctrl_t'(wdata[2:0]);
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_CTRL: rdata[RB_SEL_LSB +: 2] = {ctrl.srcb_ext, ctrl.srca_half};
         ADDR_STAT: rdata = stat;
         default:   rdata = '0;
      endcase
   end

   p_ctrl_write_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == ADDR_CTRL) |=> (ctrl == ctrl_t'($past(wdata[2:0]))));
endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer
   import adcbuf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              adc_busy,
   input  logic              timer_tick,
   input  logic              ext_trig,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              fifo_rd,
   output logic [DATA_W-1:0] fifo_rdata,
   output logic [7:0]        status,
   output logic              irq
);
   ctrl_t ctrl;
   logic  clr, empty, half, full, ovf, half_evt;

   adcbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (ctrl.fifo_dis),
      .wr_req   (conv_done),
      .wr_data  (conv_data),
      .rd_req   (fifo_rd),
      .rd_data  (fifo_rdata),
      .empty    (empty),
      .half     (half),
      .full     (full),
      .ovf      (ovf),
      .half_evt (half_evt)
   );

   always_comb begin
      status             = '0;
      status[ST_OVF]     = ovf;
      status[ST_EMPTY_N] = ~empty;
      status[ST_HALF_N]  = ~half;
      status[ST_FULL_N]  = ~full;
      status[ST_BUSY]    = adc_busy;
   end

   adcbuf_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .stat  (status),
      .ctrl  (ctrl),
      .clr   (clr),
      .rdata (reg_rdata)
   );

   adcbuf_irq u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_a_half (ctrl.srca_half),
      .sel_b_ext  (ctrl.srcb_ext),
      .conv_evt   (conv_done),
      .half_evt   (half_evt),
      .tick_evt   (timer_tick),
      .ext_evt    (ext_trig),
      .clr        (clr),
      .irq_o      (irq)
   );

   p_full_flag_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !status[ST_FULL_N] |-> (!status[ST_HALF_N] && status[ST_EMPTY_N]));
endmodule

// File: tb/adc_sample_buffer_tb.sv
module adc_sample_buffer_tb;
   localparam int DW   = 16;
   localparam int DEP  = 16;
   localparam int HALF = DEP / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_done = 0, adc_busy = 0, timer_tick = 0, ext_trig = 0;
   logic reg_wr = 0, fifo_rd = 0;
   logic [DW-1:0] conv_data = '0;
   logic [1:0] reg_addr = 2'd1;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata, status;
   logic [DW-1:0] fifo_rdata;
   logic irq;

   always #2.5 clk = ~clk;

   adc_sample_buffer #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
      .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
      .adc_busy(adc_busy), .timer_tick(timer_tick), .ext_trig(ext_trig),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
      .status(status), .irq(irq));

   int n_chk = 0, n_fail = 0;
   string tag = "R1";

   // Reference model
   int unsigned q[$];
   logic [DW-1:0] m_rd = '0;
   logic [2:0] m_ctrl = '0;
   bit m_ovf = 0, m_irq = 0;

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status();
      logic [7:0] s = '0;
      s[3] = m_ovf;
      s[4] = (q.size() != 0);
      s[5] = (q.size() < HALF);
      s[6] = (q.size() != DEP);
      s[7] = adc_busy;
      return s;
   endfunction

   function automatic logic [7:0] exp_reg();
      case (reg_addr)
         2'd0: return {2'b00, m_ctrl[1:0], 4'b0000};
         2'd1: return exp_status();
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_step();
      int sz = q.size();
      bit dis = m_ctrl[2];
      bit popok = fifo_rd && sz > 0 && !dis;
      bit pushok = conv_done && !dis && (sz < DEP || popok);
      bit hfe = pushok && !popok && (sz == HALF - 1);
      bit sa = m_ctrl[0] ? hfe : conv_done;
      bit sb = m_ctrl[1] ? ext_trig : timer_tick;
      if (dis) begin
         q.delete();
         m_ovf = 0;
      end else begin
         if (popok) m_rd = DW'(q.pop_front());
         if (pushok) q.push_back(int'(conv_data));
         if (conv_done && !pushok) m_ovf = 1;
      end
      if (sa || sb) m_irq = 1;
      else if (reg_wr && reg_addr == 2'd2) m_irq = 0;
      if (reg_wr && reg_addr == 2'd0) m_ctrl = reg_wdata[2:0];
   endtask

   // One clock: inputs already driven at the falling edge
   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk("fifo_rdata", fifo_rdata, m_rd);
      chk("irq", irq, m_irq);
      chk("status", status, exp_status());
      chk("reg_rdata", reg_rdata, exp_reg());
      conv_done = 0; fifo_rd = 0; timer_tick = 0; ext_trig = 0; reg_wr = 0;
   endtask

   task automatic push(logic [DW-1:0] d);
      conv_done = 1; conv_data = d; cyc();
   endtask
   task automatic pop();
      fifo_rd = 1; cyc();
   endtask
   task automatic wreg(logic [1:0] a, logic [7:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(); reg_addr = 2'd1;
   endtask

   initial begin
      #(20000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      tag = "R1";
      @(negedge clk);
      chk("status after reset", status, 8'h60);
      chk("irq after reset", irq, 1'b0);
      chk("rdata after reset", fifo_rdata, '0);
      reg_addr = 2'd0; #1;
      chk("ctrl readback after reset", reg_rdata, 8'h00);
      reg_addr = 2'd1;

      // R2: ordering, conversion source raises irq (R8 select 0)
      tag = "R2";
      push(16'hA001); push(16'hB002); push(16'hC003);
      pop(); pop();
      chk("second sample R2", fifo_rdata, 16'hB002);
      tag = "R10";
      wreg(2'd2, 8'h00);
      chk("irq cleared R10", irq, 1'b0);
      pop();

      // R3: empty reads hold data
      tag = "R3";
      pop(); pop();
      chk("held data R3", fifo_rdata, 16'hC003);

      // R9: timer source, then external source
      tag = "R9";
      timer_tick = 1; cyc();
      chk("tick sets irq R9", irq, 1'b1);
      wreg(2'd0, 8'h02);
      wreg(2'd2, 8'h00);
      timer_tick = 1; cyc();
      chk("tick ignored R9", irq, 1'b0);
      ext_trig = 1; cyc();
      chk("ext sets irq R9", irq, 1'b1);

      // R10: clear collides with event
      tag = "R10";
      ext_trig = 1; reg_wr = 1; reg_addr = 2'd2; cyc(); reg_addr = 2'd1;
      chk("set wins R10", irq, 1'b1);
      repeat (3) cyc();

      // R8: half-full source
      tag = "R8";
      wreg(2'd0, 8'h01);
      wreg(2'd2, 8'h00);
      for (int i = 0; i < HALF - 1; i++) push(DW'(16'h1000 + i));
      chk("no irq below half R8", irq, 1'b0);
      push(16'h1FFF);
      chk("irq at half R8", irq, 1'b1);
      wreg(2'd2, 8'h00);

      // R4 and R5: fill, overflow, pop-while-full
      tag = "R4";
      for (int i = 0; i < HALF; i++) push(DW'(16'h2000 + i));
      chk("full flags R4", status[6:4], 3'b001);
      tag = "R5";
      push(16'hDEAD);
      chk("overflow set R5", status[3], 1'b1);
      conv_done = 1; conv_data = 16'hBEEF; fifo_rd = 1; cyc();
      chk("pop while full R5", fifo_rdata, 16'h1000);
      pop(); pop();
      chk("overflow sticky R5", status[3], 1'b1);

      // R6: busy mirror
      tag = "R6";
      adc_busy = 1; cyc();
      chk("busy bit R6", status[7], 1'b1);
      adc_busy = 0; cyc();

      // R7: enable, disable, enable empties store
      tag = "R7";
      wreg(2'd0, 8'h00);
      wreg(2'd0, 8'h04);
      push(16'h7777);
      wreg(2'd0, 8'h00);
      chk("emptied R7", status[4], 1'b0);
      chk("overflow cleared R7", status[3], 1'b0);

      // R11: readback and spare addresses
      tag = "R11";
      wreg(2'd0, 8'hFB);
      reg_addr = 2'd0; cyc();
      chk("readback R11", reg_rdata, 8'h30);
      reg_addr = 2'd3; cyc();
      chk("spare addr R11", reg_rdata, 8'h00);
      reg_addr = 2'd1;
      wreg(2'd0, 8'h00);

      // Mixed traffic against the model (R2)
      tag = "R2";
      for (int i = 0; i < 2000; i++) begin
         int unsigned r = $urandom;
         conv_done  = r[0] | r[1];
         conv_data  = DW'(r >> 8);
         fifo_rd    = r[2] & r[3];
         timer_tick = (r[7:4] == 4'h0);
         ext_trig   = (r[7:4] == 4'h1);
         adc_busy   = r[24];
         reg_addr   = r[26:25];
         reg_wr     = (r[31:28] == 4'h0);
         reg_wdata  = (r[27] ? 8'h00 : {5'b0, r[29] & r[30], r[5], r[6]});
         cyc();
      end
      reg_addr = 2'd1;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule